// File: doc/BRIEF.md
# Dual-Configuration CAN FD Bit Timer

This block is the bit timing engine of a CAN FD protocol controller. It divides the system clock into time quanta and steps through each bit as a one-quantum synchronization segment, a first phase segment that covers propagation and phase 1, and a second phase segment. At the end of the first phase segment it issues a sample strobe and captures the receive line. On the last clock of every bit it raises a bit-end pulse, which the transmit path uses to launch the next bit.

The block holds two full timing sets: one for the arbitration phase and one for the faster data phase. Each set has its own prescaler, phase-1 length, phase-2 length and jump width. On a request from the frame processor the block swaps sets at a sample point. Because of this, the bit carrying the rate switch and the bit where the rate returns are each of mixed length, and together they last one arbitration bit plus one data bit. A one-cycle abort input drops back to the arbitration set at once. The block hard-synchronizes on a falling edge of the receive line while the bus is idle. Otherwise it resynchronizes within the jump width. A node that is transmitting ignores late edges. A data set whose bit time is longer than the arbitration bit time is flagged, and switching to it is refused.

Top module: `canfd_bit_timer`

## Requirements
- R1: While reset is asserted, data_phase is 0 and rx_bit is 1 (recessive), and the arbitration set is active.
- R2: A time quantum lasts presc+1 system clocks. With no falling edges on rx, sample_strobe recurs every (presc+1)*(1+seg1+seg2) clocks of the active set. sample_strobe fires on the last clock of the first phase segment.
- R3: On each sample_strobe, rx_bit takes the value rx has in that clock. It holds that value until the next strobe.
- R4: When go_data is high during a sample_strobe in the arbitration phase and cfg_err is 0, data_phase becomes 1 on the next clock. The prescaler restarts with the data set, and the next strobe follows one data bit time later.
- R5: When go_arb is high during a sample_strobe in the data phase, data_phase becomes 0 on the next clock. The bit containing the switch lasts (1+seg1) arbitration quanta plus seg2 data quanta. The bit containing the return lasts (1+seg1) data quanta plus seg2 arbitration quanta. The two together equal one arbitration bit plus one data bit.
- R6: err_abort high during the data phase clears data_phase on the next clock and restarts the current quantum with the arbitration prescaler. All later bits use arbitration timing.
- R7: cfg_err is 1 exactly when the data bit time in clocks exceeds the arbitration bit time. Equal times are allowed. While cfg_err is 1, go_data is ignored and the arbitration set stays active.
- R8: A receiver that sees a falling edge on rx during quantum j (counting from 0) of the first phase segment lengthens that segment by min(j+1, sjw) quanta. Only one such adjustment is made per bit.
- R9: While tx_mode is 1, falling edges during the first phase segment have no effect on timing.
- R10: A falling edge during the second phase segment, with r quanta of that segment left including the current one, works as follows. If r <= sjw, the current quantum becomes the synchronization segment of the next bit and bit_end pulses in that clock. Otherwise the segment is shortened by sjw quanta.
- R11: Falling edges inside the synchronization segment, and all rising edges, leave timing unchanged.
- R12: With bus_idle high, a falling edge on rx in clock t restarts the bit (hard sync). The next sample_strobe then comes at clock t+(presc+1)*(1+seg1).
- R13: bit_end is high on the last clock of every bit and never in the same clock as sample_strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_presc | input | PRE_W | Arbitration quantum length minus one, in clocks |
| arb_seg1 | input | SEG1_W | Arbitration propagation plus phase 1, in quanta (1..64) |
| arb_seg2 | input | SEG2_W | Arbitration phase 2, in quanta (1..16) |
| arb_sjw | input | SJW_W | Arbitration jump width, in quanta (1..16) |
| dat_presc | input | PRE_W | Data quantum length minus one, in clocks |
| dat_seg1 | input | SEG1_W | Data propagation plus phase 1, in quanta (1..64) |
| dat_seg2 | input | SEG2_W | Data phase 2, in quanta (1..16) |
| dat_sjw | input | SJW_W | Data jump width, in quanta (1..16) |
| rx | input | 1 | Receive line, already synchronized to clk |
| tx_mode | input | 1 | Node is currently transmitting |
| bus_idle | input | 1 | Bus is idle; falling edges hard-synchronize |
| go_data | input | 1 | Switch to the data set at the next sample point |
| go_arb | input | 1 | Return to the arbitration set at the next sample point |
| err_abort | input | 1 | Error frame starts; return to the arbitration set at once |
| sample_strobe | output | 1 | Sample point of the current bit |
| rx_bit | output | 1 | Last sampled bit value |
| bit_end | output | 1 | Last clock of the current bit |
| data_phase | output | 1 | Data set is active |
| cfg_err | output | 1 | Data bit time exceeds arbitration bit time |

## Verification
The assertions assume the following about the inputs. The timing sets stay within their legal ranges, with every segment length and jump width at least one. They change only while the arbitration set is active. err_abort is a single-cycle pulse. The stimulus respects this: it reprograms both sets only between frames, draws random lengths from the legal ranges, and derives cfg_err from its own bit-time products. The directed cases place each falling edge on the first clock of a chosen quantum, with the prescaler at least one. That keeps edges off quantum ticks, so the expected strobe clock follows directly from the quantum arithmetic.

// File: rtl/canfd_bit_timer.sv
`timescale 1ns/1ps
module canfd_bit_timer #(
  parameter int PRE_W  = 8,
  parameter int SEG1_W = 7,
  parameter int SEG2_W = 5,
  parameter int SJW_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRE_W-1:0]  arb_presc,
  input  logic [SEG1_W-1:0] arb_seg1,
  input  logic [SEG2_W-1:0] arb_seg2,
  input  logic [SJW_W-1:0]  arb_sjw,
  input  logic [PRE_W-1:0]  dat_presc,
  input  logic [SEG1_W-1:0] dat_seg1,
  input  logic [SEG2_W-1:0] dat_seg2,
  input  logic [SJW_W-1:0]  dat_sjw,
  input  logic              rx,
  input  logic              tx_mode,
  input  logic              bus_idle,
  input  logic              go_data,
  input  logic              go_arb,
  input  logic              err_abort,
  output logic              sample_strobe,
  output logic              rx_bit,
  output logic              bit_end,
  output logic              data_phase,
  output logic              cfg_err
);
  localparam int QW  = SEG1_W + 1;
  localparam int BTW = PRE_W + QW + 2;

  typedef enum logic [1:0] {SG_SYNC = 2'd0, SG_PH1 = 2'd1, SG_PH2 = 2'd2} seg_t;

  function automatic logic [BTW-1:0] bit_clks(input logic [PRE_W-1:0] p,
                                               input logic [SEG1_W-1:0] a,
                                               input logic [SEG2_W-1:0] b);
    logic [BTW-1:0] nq;
    nq = BTW'(a) + BTW'(b) + BTW'(1);
    return (BTW'(p) + BTW'(1)) * nq;
  endfunction

  logic [PRE_W-1:0] pc;
  seg_t             seg;
  logic [QW-1:0]    qc, ext;
  logic [SJW_W-1:0] shr;
  logic             rx_q;

  wire [PRE_W-1:0]  c_pre = data_phase ? dat_presc : arb_presc;
  wire [SEG1_W-1:0] c_s1  = data_phase ? dat_seg1  : arb_seg1;
  wire [SEG2_W-1:0] c_s2  = data_phase ? dat_seg2  : arb_seg2;
  wire [SJW_W-1:0]  c_sjw = data_phase ? dat_sjw   : arb_sjw;

  assign cfg_err = bit_clks(dat_presc, dat_seg1, dat_seg2) > bit_clks(arb_presc, arb_seg1, arb_seg2);

  wire          tick     = pc >= c_pre;
  wire          fall     = rx_q & ~rx;
  wire [QW-1:0] qn       = qc + 1'b1;
  wire [QW-1:0] sjw_q    = QW'(c_sjw);
  wire [QW-1:0] s1_lim   = QW'(c_s1) + ext;
  wire [QW-1:0] s2_lim   = QW'(c_s2) - QW'(shr);
  wire [QW-1:0] s2_left  = s2_lim - qc;
  wire          hard     = fall & bus_idle;
  wire          abort    = err_abort & data_phase;
  wire          late     = fall & ~bus_idle & ~tx_mode & (seg == SG_PH1) & (ext == '0);
  wire          early    = fall & ~bus_idle & (seg == SG_PH2) & (shr == '0);
  wire          cut      = early & (s2_left <= sjw_q);
  wire [QW-1:0] late_amt = (qn < sjw_q) ? qn : sjw_q;
  wire          p1_end   = tick & (seg == SG_PH1) & (qn >= s1_lim);
  wire          p2_end   = tick & (seg == SG_PH2) & (qn >= s2_lim);

  assign sample_strobe = ~hard & ~abort & p1_end;
  assign bit_end       = ~hard & ~abort & (cut | p2_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc         <= '0;
      seg        <= SG_SYNC;
      qc         <= '0;
      ext        <= '0;
      shr        <= '0;
      rx_q       <= 1'b1;
      rx_bit     <= 1'b1;
      data_phase <= 1'b0;
    end else begin
      rx_q <= rx;
      if (hard) begin
        pc  <= '0;
        seg <= SG_SYNC;
        qc  <= '0;
        ext <= '0;
        shr <= '0;
      end else if (abort) begin
        data_phase <= 1'b0;
        pc         <= '0;
        ext        <= '0;
        shr        <= '0;
      end else begin
        pc <= tick ? '0 : pc + 1'b1;
        if (cut) begin
          seg <= SG_SYNC;
          qc  <= '0;
          shr <= '0;
        end else begin
          if (late)  ext <= late_amt;
          if (early) shr <= c_sjw;
          if (tick) begin
            case (seg)
              SG_SYNC: begin
                seg <= SG_PH1;
                qc  <= '0;
              end
              SG_PH1: begin
                if (qn >= s1_lim) begin
                  seg    <= SG_PH2;
                  qc     <= '0;
                  ext    <= '0;
                  rx_bit <= rx;
                  if (go_data && !data_phase && !cfg_err) data_phase <= 1'b1;
                  else if (go_arb && data_phase)           data_phase <= 1'b0;
                end else begin
                  qc <= qn;
                end
              end
              SG_PH2: begin
                if (qn >= s2_lim) begin
                  seg <= SG_SYNC;
                  qc  <= '0;
                  shr <= '0;
                end else begin
                  qc <= qn;
                end
              end
              default: seg <= SG_SYNC;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/canfd_bit_timer_chk.sv
`timescale 1ns/1ps
module canfd_bit_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic rx,
  input logic go_data,
  input logic go_arb,
  input logic err_abort,
  input logic sample_strobe,
  input logic rx_bit,
  input logic bit_end,
  input logic data_phase,
  input logic cfg_err
);
  AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> rx_bit == $past(rx)); // R3
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_strobe |=> $stable(rx_bit)); // R3
  AST_SWITCH_ONLY_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
    !data_phase && !(sample_strobe && go_data && !cfg_err) |=> !data_phase); // R4
  AST_RETURN_ONLY_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase && !err_abort && !(sample_strobe && go_arb) |=> data_phase); // R5
  AST_ABORT_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase && err_abort |=> !data_phase); // R6
  AST_CFG_BLOCKS_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    !data_phase && cfg_err |=> !data_phase); // R7
  AST_END_NOT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_strobe && bit_end)); // R13
endmodule

bind canfd_bit_timer canfd_bit_timer_chk u_chk (.*);

// File: tb/canfd_bit_timer_tb.sv
`timescale 1ns/1ps
module canfd_bit_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] arb_presc, dat_presc;
  logic [6:0] arb_seg1, dat_seg1;
  logic [4:0] arb_seg2, dat_seg2, arb_sjw, dat_sjw;
  logic rx = 1'b1, tx_mode = 1'b0, bus_idle = 1'b0;
  logic go_data = 1'b0, go_arb = 1'b0, err_abort = 1'b0;
  logic sample_strobe, rx_bit, bit_end, data_phase, cfg_err;

  int cyc = 0, checks = 0, errors = 0, last_be = -1;
  bit done = 1'b0;

  canfd_bit_timer u_dut (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (cyc >= 190000 && !done) begin
    errors++;
    $display("FAIL watchdog actual=%0d expected=<190000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic int bitc(int p, int s1, int s2);
    return (p + 1) * (1 + s1 + s2);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick1();
    @(negedge clk);
    if (bit_end) last_be = cyc;
  endtask

  task automatic wait_sp(output int t);
    int n = 0;
    do begin tick1(); n++; end while (!sample_strobe && n < 5000);
    if (!sample_strobe) chk("R2 strobe timeout", 0, 1);
    t = cyc;
  endtask

  task automatic edge_at(int c);
    while (cyc < c) tick1();
    rx = 1'b0;
  endtask

  task automatic resync_case(string req, int off, int exp_len);
    int t0, t1;
    wait_sp(t0);
    edge_at(t0 + off);
    wait_sp(t1);
    chk(req, t1 - t0, exp_len);
    tick1();
    rx = 1'b1;
    wait_sp(t0);
  endtask

  task automatic set_arb(int p, int s1, int s2, int j);
    arb_presc = 8'(p); arb_seg1 = 7'(s1); arb_seg2 = 5'(s2); arb_sjw = 5'(j);
  endtask

  task automatic set_dat(int p, int s1, int s2, int j);
    dat_presc = 8'(p); dat_seg1 = 7'(s1); dat_seg2 = 5'(s2); dat_sjw = 5'(j);
  endtask

  initial begin
    int t, t0, t1, t2, t3, t4, be0, be1, brs, dlm;
    bit v, vp;
    void'($urandom(32'd2024));
    set_arb(3, 11, 4, 3);
    set_dat(1, 5, 2, 2);
    repeat (3) tick1();
    chk("R1 data_phase in reset", data_phase, 0);
    chk("R1 rx_bit in reset", rx_bit, 1);
    chk("R7 legal sets", cfg_err, 0);
    rst_n = 1'b1;

    wait_sp(t0);
    for (int i = 0; i < 3; i++) begin
      wait_sp(t1);
      chk("R2 arbitration bit period", t1 - t0, 64);
      t0 = t1;
    end

    vp = 1'b1;
    for (int i = 0; i < 12; i++) begin
      wait_sp(t);
      tick1();
      if (i > 0) chk("R3 sampled bit", rx_bit, vp);
      v = 1'($urandom);
      rx = v;
      vp = v;
    end
    rx = 1'b1;
    wait_sp(t); wait_sp(t);

    resync_case("R8 late edge j=0", 21, 68);
    resync_case("R8 late edge j=5 capped by sjw", 41, 76);
    tx_mode = 1'b1;
    resync_case("R9 transmitter ignores late edge", 41, 64);
    tx_mode = 1'b0;
    resync_case("R10 early edge shortens by sjw", 1, 52);
    resync_case("R11 edge in sync segment", 17, 64);

    wait_sp(t0);
    edge_at(t0 + 9);
    #1;
    chk("R10 bit_end on cut edge", bit_end, 1);
    wait_sp(t1);
    chk("R10 early edge within sjw", t1 - t0, 56);
    tick1(); rx = 1'b1; wait_sp(t);

    bus_idle = 1'b1;
    wait_sp(t0);
    edge_at(t0 + 10);
    t = cyc;
    wait_sp(t1);
    chk("R12 hard sync to strobe", t1 - t, 48);
    bus_idle = 1'b0;
    tick1(); rx = 1'b1; wait_sp(t);

    tick1(); go_data = 1'b1;
    wait_sp(t0); be0 = last_be;
    tick1(); go_data = 1'b0;
    chk("R4 data_phase after switch", data_phase, 1);
    wait_sp(t1);
    chk("R4 data bit period", t1 - t0, 16);
    brs = last_be - be0;
    chk("R5 switch bit length", brs, 52);
    wait_sp(t2);
    chk("R4 data bit period repeat", t2 - t1, 16);
    tick1(); go_arb = 1'b1;
    wait_sp(t3); be1 = last_be;
    tick1(); go_arb = 1'b0;
    chk("R5 data_phase after return", data_phase, 0);
    wait_sp(t4);
    chk("R5 arbitration period after return", t4 - t3, 64);
    dlm = last_be - be1;
    chk("R5 return bit length", dlm, 28);
    chk("R5 boundary pair sum", brs + dlm, 64 + 16);

    tick1(); go_data = 1'b1;
    wait_sp(t); tick1(); go_data = 1'b0;
    repeat (5) tick1();
    err_abort = 1'b1; tick1(); err_abort = 1'b0;
    chk("R6 abort clears data_phase", data_phase, 0);
    wait_sp(t0); wait_sp(t1);
    chk("R6 arbitration timing after abort", t1 - t0, 64);

    set_dat(7, 20, 4, 2);
    #1 chk("R7 long data bit flagged", cfg_err, 1);
    tick1(); go_data = 1'b1;
    wait_sp(t0); tick1();
    chk("R7 switch refused", data_phase, 0);
    wait_sp(t1);
    chk("R7 arbitration held", t1 - t0, 64);
    go_data = 1'b0;
    set_dat(3, 11, 4, 2);
    #1 chk("R7 equal bit time allowed", cfg_err, 0);
    set_dat(1, 5, 2, 2);

    for (int i = 0; i < 14; i++) begin
      int pa, sa1, sa2, pd, sd1, sd2, a, d;
      pa = $urandom % 4; sa1 = 1 + $urandom % 64; sa2 = 1 + $urandom % 16;
      pd = $urandom % 4; sd1 = 1 + $urandom % 32; sd2 = 1 + $urandom % 16;
      set_arb(pa, sa1, sa2, 1);
      set_dat(pd, sd1, sd2, 1);
      a = bitc(pa, sa1, sa2);
      d = bitc(pd, sd1, sd2);
      #1 chk("R7 random flag", cfg_err, int'(d > a));
      wait_sp(t); wait_sp(t0); wait_sp(t1);
      chk("R2 random arbitration period", t1 - t0, a);
      tick1(); go_data = 1'b1;
      wait_sp(t0); be0 = last_be;
      tick1(); go_data = 1'b0;
      if (d > a) begin
        chk("R7 random switch refused", data_phase, 0);
      end else begin
        wait_sp(t1);
        chk("R4 random data period", t1 - t0, d);
        chk("R5 random switch bit", last_be - be0, (1 + sa1) * (pa + 1) + sd2 * (pd + 1));
        tick1(); go_arb = 1'b1;
        wait_sp(t2); be1 = last_be;
        tick1(); go_arb = 1'b0;
        wait_sp(t3);
        chk("R5 random return period", t3 - t2, a);
        chk("R5 random return bit", last_be - be1, (1 + sd1) * (pd + 1) + sa2 * (pa + 1));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule